// File: doc/BRIEF.md
# Linked-List DMA Descriptor Engine

This block is the control engine of one DMA channel. It walks a chain of transfer descriptors kept in system memory. Software first writes the address of the first descriptor, then sets the channel enable bit. The engine then reads one descriptor at a time through a single-outstanding memory master port. Each descriptor has five words, and the engine loads all five into the channel registers. It then runs a buffer transfer on an internal countdown data mover. When the transfer ends, it writes the updated control word back to the place it came from.

After each write-back, the engine raises a buffer-complete flag. It moves on to the next descriptor straight away and does not wait for software to clear that flag. The chain ends when the next pointer is zero or when the descriptor's stop bit is set. At that point the engine raises a chain-complete flag, clears the enable bit and goes idle. Software can poll the done bit in the in-memory copy of each descriptor to see which buffers have finished. It can also read and clear the two flags through a read strobe.

Top module: `lldma_chain_engine`

## Requirements
- R1: After reset, chan_en is 0, irq_flags is 2'b00, mem_req_valid is 0 and xfer_busy is 0.
- R2: A write of 1 to the enable bit while idle starts the chain. The engine reads the descriptor at the address held in cur_next: source at +0, destination at +4, next pointer at +8, control A at +12 and control B at +16, in that order. Pointer writes are taken only while the engine is idle.
- R3: The memory port has at most one access in flight. Once mem_req_valid rises, it stays high with the same address and direction until mem_req_ready. Each descriptor word is read by exactly one handshake.
- R4: In control word A, bits [15:0] hold the buffer size and bit 31 is DONE. DONE is cleared when the word is loaded. The mover keeps xfer_busy high for size+1 cycles, and the size field counts down to 0.
- R5: Each buffer ends with exactly one write. It goes to the descriptor base + 12, and its data is control word A with the size field at 0 and DONE at 1.
- R6: Each write-back sets irq_flags[0]. The next descriptor, at the current next pointer, is fetched without that flag being cleared.
- R7: After a write-back, the chain ends if the next pointer is 0 or bit 31 of control B is 1. The engine then sets irq_flags[1], clears chan_en and issues no further access.
- R8: A one-cycle pulse on irq_rd clears both flags.
- R9: Writing 0 to the enable bit during a fetch lets the access in flight complete. The engine then goes idle without starting a buffer or writing memory.
- R10: cur_src, cur_dst and cur_ctlb hold the words last loaded from a descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ptr_wr | input | 1 | Write strobe for the first-descriptor pointer |
| ptr_wdata | input | AW | Pointer value |
| en_wr | input | 1 | Write strobe for the channel enable bit |
| en_wdata | input | 1 | Enable value written |
| irq_rd | input | 1 | Read of the flag register; clears the flags |
| irq_flags | output | 2 | bit 0 buffer complete, bit 1 chain complete |
| chan_en | output | 1 | Channel enable bit |
| xfer_busy | output | 1 | Buffer transfer in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | AW | Byte address of the request |
| mem_req_wdata | output | DW | Write data |
| mem_rd_valid | input | 1 | Read data return strobe |
| mem_rd_data | input | DW | Read data |
| cur_src | output | DW | Loaded source address |
| cur_dst | output | DW | Loaded destination address |
| cur_next | output | AW | Current next-descriptor pointer |
| cur_ctla | output | DW | Control word A (size, DONE) |
| cur_ctlb | output | DW | Control word B (stop bit 31) |

## Verification
The bench builds chains of one to four descriptors at scattered addresses. The memory model in the bench uses random accept and return delays. Some descriptors have a size of zero, and some arrive with DONE already set in memory. An engine that writes back to the wrong word, writes back the wrong data or skips the DONE clear leaves the memory image or the DONE watch wrong. A mover with an off-by-one count shows up in the busy-length check.

Other cases cover the end of the chain. One chain ends on the stop bit while its next pointer is non-zero, so an engine that tests only the pointer fetches past the end. In another run, software writes the pointer while the chain is running, so an engine that accepts it would fetch from the wrong place. A disable issued while the first request waits for acceptance must leave exactly one read handshake and no transfer. An engine that drops the pending request, or one that ignores the disable, breaks that count.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_FREQ,
    ENG_FWAIT,
    ENG_XFER,
    ENG_WREQ
  } eng_state_e;

  localparam int unsigned DESC_WORDS = 5;
  localparam int unsigned IDX_W      = 3;
  localparam int unsigned IDX_SRC    = 0;
  localparam int unsigned IDX_DST    = 1;
  localparam int unsigned IDX_NEXT   = 2;
  localparam int unsigned IDX_CTLA   = 3;
  localparam int unsigned IDX_CTLB   = 4;
  localparam int unsigned IRQ_BUF    = 0;
  localparam int unsigned IRQ_CHAIN  = 1;
endpackage

// File: rtl/lldma_chan_regs.sv
module lldma_chan_regs
  import lldma_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned SIZE_W   = 16,
  parameter int unsigned DONE_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ptr_we,
  input  logic [AW-1:0]     ptr_data,
  input  logic              load_we,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [DW-1:0]     load_data,
  input  logic              base_load,
  input  logic              size_we,
  input  logic [SIZE_W-1:0] size_val,
  input  logic              done_set,
  output logic [DW-1:0]     src_q,
  output logic [DW-1:0]     dst_q,
  output logic [AW-1:0]     next_q,
  output logic [DW-1:0]     ctla_q,
  output logic [DW-1:0]     ctlb_q,
  output logic [AW-1:0]     base_q
);
  localparam logic [DW-1:0] DONE_MASK = DW'(1) << DONE_BIT;

  logic [DESC_WORDS-1:0][DW-1:0] words;

  for (genvar gi = 0; gi < DESC_WORDS; gi++) begin : g_word
    logic [DW-1:0] q;
    logic          hit;
    assign hit = load_we && (load_idx == IDX_W'(gi));

    if (gi == IDX_NEXT) begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (hit)    q <= load_data;
        else if (ptr_we) q <= DW'(ptr_data);
      end
    end else if (gi == IDX_CTLA) begin : g_ctla
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          q <= load_data & ~DONE_MASK;
        end else begin
          if (size_we)  q[SIZE_W-1:0] <= size_val;
          if (done_set) q[DONE_BIT]   <= 1'b1;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= load_data;
      end
    end

    assign words[gi] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         base_q <= '0;
    else if (base_load) base_q <= next_q;
  end

  assign src_q  = words[IDX_SRC];
  assign dst_q  = words[IDX_DST];
  assign next_q = words[IDX_NEXT][AW-1:0];
  assign ctla_q = words[IDX_CTLA];
  assign ctlb_q = words[IDX_CTLB];
endmodule

// File: rtl/lldma_mover.sv
module lldma_mover #(
  parameter int unsigned SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SIZE_W-1:0] size,
  output logic              busy,
  output logic              step,
  output logic [SIZE_W-1:0] remain_nxt,
  output logic              done
);
  logic [SIZE_W-1:0] cnt_q;
  logic              busy_q;

  function automatic logic [SIZE_W-1:0] count_down(input logic [SIZE_W-1:0] c);
    return c - SIZE_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= size;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= count_down(cnt_q);
    end
  end

  assign busy       = busy_q;
  assign step       = busy_q && (cnt_q != '0);
  assign remain_nxt = count_down(cnt_q);
  assign done       = busy_q && (cnt_q == '0);
endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
  import lldma_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned STOP_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_wr,
  input  logic             en_wdata,
  input  logic             irq_rd,
  input  logic [AW-1:0]    base_q,
  input  logic [AW-1:0]    next_q,
  input  logic [DW-1:0]    ctlb_q,
  input  logic             mem_req_ready,
  input  logic             mem_rd_valid,
  input  logic             mv_done,
  output logic             mem_req_valid,
  output logic             mem_req_we,
  output logic [AW-1:0]    mem_req_addr,
  output logic             load_we,
  output logic [IDX_W-1:0] load_idx,
  output logic             base_load,
  output logic             ptr_open,
  output logic             mv_start,
  output logic             rd_wait,
  output logic             chan_en,
  output logic [1:0]       irq_flags,
  output logic             ev_wb_hs,
  output logic             ev_last,
  output logic             ev_halt
);
  localparam int unsigned WORD_BYTES = DW / 8;

  function automatic logic [AW-1:0] slot_addr(input logic [AW-1:0] b,
                                              input logic [IDX_W-1:0] i);
    return b + AW'(i) * AW'(WORD_BYTES);
  endfunction

  function automatic logic chain_ends(input logic [AW-1:0] nx, input logic [DW-1:0] cb);
    return (nx == '0) || cb[STOP_BIT];
  endfunction

  eng_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             en_q, en_d;
  logic [1:0]       flg_q;
  logic             start_ok, ev_rd, last_word;

  assign start_ok  = (st_q == ENG_IDLE) && en_wr && en_wdata;
  assign ev_rd     = (st_q == ENG_FWAIT) && mem_rd_valid;
  assign last_word = (idx_q == IDX_W'(IDX_CTLB));
  assign ev_wb_hs  = (st_q == ENG_WREQ) && mem_req_ready;
  assign ev_last   = ev_wb_hs && chain_ends(next_q, ctlb_q);

  always_comb begin
    en_d = en_q;
    if (en_wr)   en_d = en_wdata;
    if (ev_last) en_d = 1'b0;
  end

  assign ev_halt = (ev_rd && !en_d) || (ev_wb_hs && !ev_last && !en_d);

  always_comb begin
    st_d      = st_q;
    idx_d     = idx_q;
    base_load = 1'b0;
    mv_start  = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (start_ok) begin
          st_d      = ENG_FREQ;
          idx_d     = '0;
          base_load = 1'b1;
        end
      end
      ENG_FREQ: begin
        if (mem_req_ready) st_d = ENG_FWAIT;
      end
      ENG_FWAIT: begin
        if (mem_rd_valid) begin
          if (!en_d) begin
            st_d = ENG_IDLE;
          end else if (last_word) begin
            st_d     = ENG_XFER;
            mv_start = 1'b1;
          end else begin
            st_d  = ENG_FREQ;
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      ENG_XFER: begin
        if (mv_done) st_d = ENG_WREQ;
      end
      ENG_WREQ: begin
        if (mem_req_ready) begin
          if (ev_last || !en_d) begin
            st_d = ENG_IDLE;
          end else begin
            st_d      = ENG_FREQ;
            idx_d     = '0;
            base_load = 1'b1;
          end
        end
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ENG_IDLE;
      idx_q <= '0;
      en_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      en_q  <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flg_q <= '0;
    end else begin
      if (irq_rd)   flg_q                <= '0;
      if (ev_wb_hs) flg_q[IRQ_BUF]       <= 1'b1;
      if (ev_last)  flg_q[IRQ_CHAIN]     <= 1'b1;
    end
  end

  assign mem_req_valid = (st_q == ENG_FREQ) || (st_q == ENG_WREQ);
  assign mem_req_we    = (st_q == ENG_WREQ);
  assign mem_req_addr  = (st_q == ENG_WREQ) ? slot_addr(base_q, IDX_W'(IDX_CTLA))
                                            : slot_addr(base_q, idx_q);
  assign load_we       = ev_rd;
  assign load_idx      = idx_q;
  assign ptr_open      = (st_q == ENG_IDLE);
  assign rd_wait       = (st_q == ENG_FWAIT);
  assign chan_en       = en_q;
  assign irq_flags     = flg_q;
endmodule

// File: rtl/lldma_chain_engine.sv
module lldma_chain_engine
  import lldma_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned SIZE_W   = 16,
  parameter int unsigned DONE_BIT = 31,
  parameter int unsigned STOP_BIT = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic          en_wr,
  input  logic          en_wdata,
  input  logic          irq_rd,
  output logic [1:0]    irq_flags,
  output logic          chan_en,
  output logic          xfer_busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  output logic [DW-1:0] cur_src,
  output logic [DW-1:0] cur_dst,
  output logic [AW-1:0] cur_next,
  output logic [DW-1:0] cur_ctla,
  output logic [DW-1:0] cur_ctlb
);
  logic             load_we, base_load, ptr_open, mv_start, rd_wait;
  logic [IDX_W-1:0] load_idx;
  logic [AW-1:0]    desc_base, next_q;
  logic [DW-1:0]    ctla_q, ctlb_q;
  logic             mv_busy, mv_step, mv_done;
  logic [SIZE_W-1:0] mv_remain;
  logic             ev_wb_hs, ev_last, ev_halt;

  lldma_seq #(.AW(AW), .DW(DW), .STOP_BIT(STOP_BIT)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .en_wr         (en_wr),
    .en_wdata      (en_wdata),
    .irq_rd        (irq_rd),
    .base_q        (desc_base),
    .next_q        (next_q),
    .ctlb_q        (ctlb_q),
    .mem_req_ready (mem_req_ready),
    .mem_rd_valid  (mem_rd_valid),
    .mv_done       (mv_done),
    .mem_req_valid (mem_req_valid),
    .mem_req_we    (mem_req_we),
    .mem_req_addr  (mem_req_addr),
    .load_we       (load_we),
    .load_idx      (load_idx),
    .base_load     (base_load),
    .ptr_open      (ptr_open),
    .mv_start      (mv_start),
    .rd_wait       (rd_wait),
    .chan_en       (chan_en),
    .irq_flags     (irq_flags),
    .ev_wb_hs      (ev_wb_hs),
    .ev_last       (ev_last),
    .ev_halt       (ev_halt)
  );

  lldma_chan_regs #(.AW(AW), .DW(DW), .SIZE_W(SIZE_W), .DONE_BIT(DONE_BIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ptr_we    (ptr_wr && ptr_open),
    .ptr_data  (ptr_wdata),
    .load_we   (load_we),
    .load_idx  (load_idx),
    .load_data (mem_rd_data),
    .base_load (base_load),
    .size_we   (mv_step),
    .size_val  (mv_remain),
    .done_set  (mv_done),
    .src_q     (cur_src),
    .dst_q     (cur_dst),
    .next_q    (next_q),
    .ctla_q    (ctla_q),
    .ctlb_q    (ctlb_q),
    .base_q    (desc_base)
  );

  lldma_mover #(.SIZE_W(SIZE_W)) u_mover (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (mv_start),
    .size       (ctla_q[SIZE_W-1:0]),
    .busy       (mv_busy),
    .step       (mv_step),
    .remain_nxt (mv_remain),
    .done       (mv_done)
  );

  assign xfer_busy     = mv_busy;
  assign mem_req_wdata = ctla_q;
  assign cur_next      = next_q;
  assign cur_ctla      = ctla_q;
  assign cur_ctlb      = ctlb_q;
endmodule

// File: rtl/lldma_chain_engine_chk.sv
module lldma_chain_engine_chk #(
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned SIZE_W   = 16,
  parameter int unsigned DONE_BIT = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [AW-1:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata,
  input logic          rd_wait,
  input logic [AW-1:0] desc_base,
  input logic [1:0]    irq_flags,
  input logic          chan_en,
  input logic          xfer_busy,
  input logic [DW-1:0] cur_ctla,
  input logic          mv_start,
  input logic          ev_last,
  input logic          ev_halt
);
  localparam logic [AW-1:0] CTLA_OFS = AW'(3 * (DW / 8));

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  // R3
  single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wait |-> !mem_req_valid);

  // R5
  wb_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_addr == desc_base + CTLA_OFS);

  // R5
  wb_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[DONE_BIT] && (mem_req_wdata[SIZE_W-1:0] == '0));

  // R6
  buf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && mem_req_ready |=> irq_flags[0]);

  // R4
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> xfer_busy && !cur_ctla[DONE_BIT]);

  // R7
  last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> !chan_en && irq_flags[1] && !mem_req_valid);

  // R9
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_halt |=> !mem_req_valid && !xfer_busy);
endmodule

bind lldma_chain_engine lldma_chain_engine_chk #(
  .AW(AW), .DW(DW), .SIZE_W(SIZE_W), .DONE_BIT(DONE_BIT)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .rd_wait       (rd_wait),
  .desc_base     (desc_base),
  .irq_flags     (irq_flags),
  .chan_en       (chan_en),
  .xfer_busy     (xfer_busy),
  .cur_ctla      (cur_ctla),
  .mv_start      (mv_start),
  .ev_last       (ev_last),
  .ev_halt       (ev_halt)
);

// File: tb/lldma_chain_engine_bench.sv
module lldma_chain_engine_bench;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ptr_wr = 1'b0, en_wr = 1'b0, en_wdata = 1'b0, irq_rd = 1'b0;
  logic [AW-1:0] ptr_wdata = '0;
  logic [1:0]    irq_flags;
  logic          chan_en, xfer_busy, mem_req_valid, mem_req_we;
  logic          mem_req_ready = 1'b0, mem_rd_valid = 1'b0;
  logic [AW-1:0] mem_req_addr, cur_next;
  logic [DW-1:0] mem_req_wdata, mem_rd_data = '0;
  logic [DW-1:0] cur_src, cur_dst, cur_ctla, cur_ctlb;

  lldma_chain_engine u_lldma_chain_engine (
    .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .en_wr(en_wr), .en_wdata(en_wdata), .irq_rd(irq_rd), .irq_flags(irq_flags),
    .chan_en(chan_en), .xfer_busy(xfer_busy), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .cur_src(cur_src), .cur_dst(cur_dst), .cur_next(cur_next), .cur_ctla(cur_ctla),
    .cur_ctlb(cur_ctlb)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] mem [0:255];
  logic [31:0] fetch_log[$], wr_addr_log[$], wr_data_log[$];
  int          busy_log[$];
  int          busy_run = 0, ready_pct = 50, lat_cnt = 0;
  bit          rd_pend = 0, done_leak = 0;
  logic [31:0] rd_word = '0;

  function automatic int midx(input logic [31:0] a);
    return int'((a >> 2) & 32'd255);
  endfunction

  function automatic logic [31:0] wb_expect(input logic [31:0] ctla);
    return (ctla & 32'h7FFF_0000) | 32'h8000_0000;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model and monitors, all away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_req_ready = 1'b0; mem_rd_valid = 1'b0; rd_pend = 0;
    end else begin
      mem_rd_valid = 1'b0;
      if (rd_pend) begin
        if (lat_cnt == 0) begin mem_rd_valid = 1'b1; mem_rd_data = rd_word; rd_pend = 0; end
        else lat_cnt--;
      end
      mem_req_ready = mem_req_valid && (int'($urandom % 100) < ready_pct);
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[midx(mem_req_addr)] = mem_req_wdata;
          wr_addr_log.push_back(mem_req_addr);
          wr_data_log.push_back(mem_req_wdata);
        end else begin
          fetch_log.push_back(mem_req_addr);
          rd_word = mem[midx(mem_req_addr)];
          rd_pend = 1;
          lat_cnt = int'($urandom % 3);
        end
      end
      if (xfer_busy) begin
        busy_run++;
        if (cur_ctla[31]) done_leak = 1;
      end else if (busy_run > 0) begin
        busy_log.push_back(busy_run);
        busy_run = 0;
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R7 watchdog: actual %0d cycles expected fewer", 190000);
    summary();
    $finish;
  end

  task automatic set_ptr(input logic [31:0] v);
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = v;
    @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk); en_wr = 1'b1; en_wdata = v;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic read_flags();
    @(negedge clk); irq_rd = 1'b1;
    @(negedge clk); irq_rd = 1'b0;
    chk("R8", "flags after read", 32'(irq_flags), 32'd0);
  endtask

  task automatic clear_logs();
    fetch_log.delete(); wr_addr_log.delete(); wr_data_log.delete(); busy_log.delete();
    done_leak = 0;
  endtask

  task automatic run_chain(input int n, input int first, input bit use_stop,
                           input bit poke, input int fsize);
    logic [31:0] b [4];
    logic [31:0] w [4][5];
    int sz [4];
    int guard;
    for (int i = 0; i < n; i++) b[i] = 32'((((first + i * 4) % 15) + 1) * 64);
    for (int i = 0; i < n; i++) begin
      sz[i] = (fsize >= 0) ? fsize : int'($urandom % 24);
      w[i][0] = $urandom;
      w[i][1] = $urandom;
      w[i][2] = (i < n - 1) ? b[i+1] : (use_stop ? 32'h3F0 : 32'h0);
      w[i][3] = ($urandom & 32'hFFFF_0000) | 32'(sz[i]);
      w[i][4] = ($urandom & 32'h7FFF_FFFF) | ((use_stop && i == n - 1) ? 32'h8000_0000 : 32'h0);
      for (int k = 0; k < 5; k++) mem[midx(b[i] + 32'(4 * k))] = w[i][k];
    end
    clear_logs();
    set_ptr(b[0]);
    chk("R2", "pointer loaded while idle", cur_next, b[0]);
    set_en(1'b1);
    if (poke) begin
      repeat (7) @(negedge clk);
      set_ptr(32'h3F0);
      set_en(1'b1);
    end
    guard = 0;
    while (!(irq_flags[1] && !mem_req_valid && !xfer_busy) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (4) @(negedge clk);
    chk("R3", "read handshakes", 32'(fetch_log.size()), 32'(5 * n));
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 5; k++)
        if (fetch_log.size() > 5 * i + k)
          chk("R2", "fetch address order", fetch_log[5*i+k], b[i] + 32'(4 * k));
    chk("R5", "write-back count", 32'(wr_addr_log.size()), 32'(n));
    for (int i = 0; i < n; i++) begin
      if (wr_addr_log.size() > i) begin
        chk("R5", "write-back address", wr_addr_log[i], b[i] + 32'd12);
        chk("R5", "write-back data", wr_data_log[i], wb_expect(w[i][3]));
      end
      chk("R5", "memory DONE image", mem[midx(b[i] + 32'd12)], wb_expect(w[i][3]));
      chk("R2", "source word untouched", mem[midx(b[i])], w[i][0]);
    end
    chk("R4", "buffer count", 32'(busy_log.size()), 32'(n));
    for (int i = 0; i < n; i++)
      if (busy_log.size() > i) chk("R4", "busy cycles", 32'(busy_log[i]), 32'(sz[i] + 1));
    chk("R4", "DONE cleared while busy", 32'(done_leak), 32'd0);
    chk("R7", "enable cleared at end", 32'(chan_en), 32'd0);
    chk("R6", "flags at end", 32'(irq_flags), 32'd3);
    chk("R10", "source register", cur_src, w[n-1][0]);
    chk("R10", "destination register", cur_dst, w[n-1][1]);
    chk("R10", "control B register", cur_ctlb, w[n-1][4]);
    chk("R4", "size field counted down", 32'(cur_ctla[15:0]), 32'd0);
    read_flags();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R1", "chan_en at reset", 32'(chan_en), 32'd0);
    chk("R1", "flags at reset", 32'(irq_flags), 32'd0);
    chk("R1", "request at reset", 32'(mem_req_valid), 32'd0);
    chk("R1", "busy at reset", 32'(xfer_busy), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "chan_en after reset", 32'(chan_en), 32'd0);

    // directed: single descriptor of size zero, ends on null pointer
    ready_pct = 100;
    run_chain(1, 0, 1'b0, 1'b0, 0);
    // directed: three descriptors, ends on stop bit with non-zero pointer
    ready_pct = 40;
    run_chain(3, 2, 1'b1, 1'b0, -1);
    // directed: pointer and enable writes while the chain runs
    ready_pct = 70;
    run_chain(4, 5, 1'b0, 1'b1, -1);

    // R9: disable while the first request waits for acceptance
    ready_pct = 0;
    clear_logs();
    mem[midx(32'h80)] = 32'hA5A5_0001;
    set_ptr(32'h80);
    set_en(1'b1);
    while (!mem_req_valid) @(negedge clk);
    en_wr = 1'b1; en_wdata = 1'b0;
    @(negedge clk); en_wr = 1'b0;
    ready_pct = 50;
    repeat (40) @(negedge clk);
    chk("R9", "reads after disable", 32'(fetch_log.size()), 32'd1);
    chk("R9", "writes after disable", 32'(wr_addr_log.size()), 32'd0);
    chk("R9", "buffers after disable", 32'(busy_log.size()), 32'd0);
    chk("R9", "request idle", 32'(mem_req_valid), 32'd0);
    chk("R9", "flags untouched", 32'(irq_flags), 32'd0);
    chk("R9", "enable bit", 32'(chan_en), 32'd0);

    for (int r = 0; r < 8; r++) begin
      ready_pct = 20 + int'($urandom % 81);
      run_chain(1 + int'($urandom % 4), int'($urandom % 15), 1'(($urandom % 2)), 1'b0, -1);
    end

    summary();
    $finish;
  end
endmodule